// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for burst accesses to a synchronous SRAM. A burst begins when either of two address strobes is accepted: a processor-side strobe, which counts only while the chip-enable input is active, or a controller-side strobe, which needs no enable. Either strobe captures the external address. The low two bits of the address then step through a four-word group. They move only in cycles where the advance input is high, and the upper bits stay fixed until the next load.

The step order is chosen when the burst loads. A linear burst increments the low bits and wraps modulo four. An interleaved burst XORs the starting low bits with an internal step count, so a start of 1 gives 1, 0, 3, 2. When no order has been latched, the block uses interleaved order, set by a parameter. Bursting is optional: a new address can be loaded on every cycle. A one-cycle flag marks the first address of each burst.

Top module: `burst_seq`

## Requirements
- R1: After reset, addrOut is all zero and burstStart is low.
- R2: When procStrobe is high and chipEnable is high at a clock edge, addrOut equals the sampled addrIn after that edge, and burstStart is high for that one cycle.
- R3: When ctrlStrobe is high at a clock edge, addrIn is loaded in the same way as in R2, whatever the level of chipEnable.
- R4: When procStrobe is high and chipEnable is low, the strobe is ignored: without ctrlStrobe, burstStart stays low and addrOut follows only the advance input.
- R5: Each edge with advance high and no accepted strobe moves the low two bits one step in the burst order. The upper bits stay equal to the loaded address, and the sequence repeats after four steps.
- R6: With linearSel high at the load edge, after k steps the low bits equal (start + k) mod 4.
- R7: With linearSel low at the load edge, after k steps the low bits equal start XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R8: The order is latched at the load edge. A change on linearSel during a burst has no effect until the next load.
- R9: An edge with no accepted strobe and advance low leaves addrOut unchanged.
- R10: An accepted strobe takes priority over advance in the same cycle. Strobes on consecutive edges each load a new address, with burstStart high in each of those cycles.
- R11: When both strobes are accepted at the same edge, the block performs exactly one load of addrIn with burstStart high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| procStrobe | input | 1 | Processor-side burst start, qualified by chipEnable |
| ctrlStrobe | input | 1 | Controller-side burst start, unqualified |
| chipEnable | input | 1 | Enables acceptance of procStrobe (high = enabled) |
| advance | input | 1 | Step the burst by one word |
| linearSel | input | 1 | Order strap sampled on load: 1 linear, 0 interleaved |
| addrIn | input | ADDR_W | External address |
| addrOut | output | ADDR_W | Current array address |
| burstStart | output | 1 | High for the first address of a burst |

## Verification
Loading and advancing can be requested in the same cycle. The two strobes can also arrive together, and a gated processor strobe can coincide with an advance. The bench sets up each of these pairs on purpose. It judges the result from addrOut and burstStart after the edge. A strobe must replace the address and restart the order. A strobe that is ignored must leave the advance to take effect as if the strobe were absent.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;

  function automatic logic [1:0] orderLow2(input logic [1:0] startLow,
                                            input logic [1:0] stepCnt,
                                            input logic       isLinear);
    return isLinear ? (startLow + stepCnt) : (startLow ^ stepCnt);
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procStrobe,
  input  logic        ctrlStrobe,
  input  logic        chipEnable,
  input  logic        advance,
  output seqStrobes_t strobes
);

  logic procOk;

  always_comb begin
    procOk       = procStrobe && chipEnable;
    strobes.load = procOk || ctrlStrobe;
    strobes.step = advance && !strobes.load;
  end

  // R10: a load and a step never go to the datapath together
  p_load_beats_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.step));

  // R4: a gated processor strobe alone causes no load
  p_gated_proc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && !chipEnable && !ctrlStrobe) |-> !strobes.load);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int  ADDR_W            = 15,
  parameter bit  DEFAULT_INTERLEAVE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              linearSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              burstStart
);

  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  stepCnt;
  logic              linearMode;
  logic              startFlag;
  logic [CNT_W-1:0]  lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr   <= '0;
      stepCnt    <= '0;
      linearMode <= !DEFAULT_INTERLEAVE;
      startFlag  <= 1'b0;
    end else if (strobes.load) begin
      baseAddr   <= addrIn;
      stepCnt    <= '0;
      linearMode <= linearSel;
      startFlag  <= 1'b1;
    end else begin
      startFlag <= 1'b0;
      if (strobes.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    lowBits = orderLow2(baseAddr[CNT_W-1:0], stepCnt, linearMode);
    addrOut = {baseAddr[ADDR_W-1:CNT_W], lowBits};
  end

  assign burstStart = startFlag;

  // R2: a load presents the captured address and the start flag
  p_load_shows_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (burstStart && addrOut == $past(addrIn)));

  // R5: upper bits do not move without a load
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(addrOut[ADDR_W-1:CNT_W]));

  // R9: no load and no step holds the address
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(addrOut));

  // R10: the start flag lasts one cycle unless reloaded
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> !burstStart);

  // R6: a linear step increments the low bits modulo four
  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && linearMode) |=>
      (addrOut[CNT_W-1:0] == CNT_W'($past(addrOut[CNT_W-1:0]) + 1'b1)));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W             = 15,
  parameter bit DEFAULT_INTERLEAVE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipEnable,
  input  logic              advance,
  input  logic              linearSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              burstStart
);

  seqStrobes_t strobes;

  burst_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .chipEnable (chipEnable),
    .advance    (advance),
    .strobes    (strobes)
  );

  burst_seq_dp #(
    .ADDR_W             (ADDR_W),
    .DEFAULT_INTERLEAVE (DEFAULT_INTERLEAVE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .linearSel  (linearSel),
    .addrIn     (addrIn),
    .addrOut    (addrOut),
    .burstStart (burstStart)
  );

  // R3: the controller strobe always starts a burst
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrobe |=> (burstStart && addrOut == $past(addrIn)));

endmodule

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;

  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobe = 1'b0, ctrlStrobe = 1'b0, chipEnable = 1'b0;
  logic          advance = 1'b0, linearSel = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic          burstStart;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  burst_seq uut (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .chipEnable(chipEnable), .advance(advance), .linearSel(linearSel),
    .addrIn(addrIn), .addrOut(addrOut), .burstStart(burstStart)
  );

  task automatic cyc(input logic p, input logic c, input logic ce,
                     input logic adv, input logic lin, input logic [AW-1:0] a);
    procStrobe = p; ctrlStrobe = c; chipEnable = ce;
    advance = adv; linearSel = lin; addrIn = a;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] expA, input logic expS);
    total++;
    if (addrOut !== expA || burstStart !== expS) begin
      bad++;
      $display("FAIL %s: addrOut=%h burstStart=%b expected addrOut=%h burstStart=%b",
               req, addrOut, burstStart, expA, expS);
    end
  endtask

  function automatic logic [1:0] expLow(input logic [1:0] s, input int k, input bit lin);
    return lin ? 2'(s + k) : (s ^ 2'(k));
  endfunction

  initial begin
    logic [AW-1:0] cur;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", '0, 1'b0);
    rstN = 1'b1;
    cyc(0,0,0,0,0,'0);
    chk("R1 idle after reset", '0, 1'b0);

    // Sweep: both orders, every start, full wrap, with a suspend cycle (R5 R6 R7 R9)
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        cur = AW'((lin * 4 + s) * 1000 + 77) & ~AW'(3) | AW'(s);
        if (s[0]) cyc(1,0,1,0,lin[0],cur); else cyc(0,1,0,0,lin[0],cur);
        chk(s[0] ? "R2 proc load" : "R3 ctrl load", cur, 1'b1);
        for (int k = 1; k <= 5; k++) begin
          cyc(0,0,1,1,~lin[0],'0);
          chk(lin ? "R6 linear step" : "R7 interleave step",
              {cur[AW-1:2], expLow(cur[1:0], k, lin[0])}, 1'b0);
          if (k == 2) begin
            cyc(0,0,1,0,lin[0],'1);
            chk("R9 suspend hold", {cur[AW-1:2], expLow(cur[1:0], k, lin[0])}, 1'b0);
          end
        end
      end
    end

    // R4: gated processor strobe, alone and with advance
    cur = 15'h1235;
    cyc(0,1,0,0,1,cur);
    chk("R3 ctrl load with enable low", cur, 1'b1);
    cyc(1,0,0,0,1,15'h7FFF);
    chk("R4 gated strobe ignored", cur, 1'b0);
    cyc(1,0,0,1,1,15'h7FFF);
    chk("R4 gated strobe, advance applies", {cur[AW-1:2], 2'd2}, 1'b0);

    // R10: strobe beats advance; back-to-back loads
    cyc(1,0,1,1,0,15'h4441);
    chk("R10 strobe over advance", 15'h4441, 1'b1);
    for (int i = 0; i < 4; i++) begin
      cyc(i[0],~i[0],1,1,0,AW'(16'h0100 * (i + 1) + i));
      chk("R10 back-to-back load", AW'(16'h0100 * (i + 1) + i), 1'b1);
    end

    // R11: both strobes together
    cyc(1,1,1,0,0,15'h2AA2);
    chk("R11 both strobes", 15'h2AA2, 1'b1);
    cyc(0,0,1,1,0,'0);
    chk("R11 one load then step", 15'h2AA3, 1'b0);

    // R8: order latched at load
    cyc(0,1,1,0,1,15'h0011);
    chk("R8 linear load", 15'h0011, 1'b1);
    cyc(0,0,1,1,0,'0);
    chk("R8 mode change ignored", 15'h0012, 1'b0);
    cyc(0,0,1,1,0,'0);
    chk("R8 mode change ignored 2", 15'h0013, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule